// File: doc/BRIEF.md
# Baseband IQ Sample Packer and Half-Rate Write Bridge

This block sits at the output of a digital down-converter. Each clock in which the sample-valid strobe is high delivers one signed 7-bit I value and one signed 7-bit Q value. The block converts both values to offset binary by inverting their sign bit. It places them in a 16-bit word with zero pad bits above each field. It then joins two consecutive words into one 32-bit write toward a downstream buffer that runs at half the sample rate.

The same writes are counted into fixed-length packets. When a write carries the last sample of a packet, a packet-end flag is raised together with it, and counting starts again from zero. The pairing is a two-state machine. In `ST_EMPTY` no sample is held. The transition `take_first` (valid sample in `ST_EMPTY`) stores the word and enters `ST_HELD`. In `ST_HELD`, the transition `emit_pair` (valid sample in `ST_HELD`) issues the 32-bit write and returns to `ST_EMPTY`. Reset forces `ST_EMPTY`. The packet length `PKT_SAMPLES` must be even, and its default is 734 samples, which is 1468 bytes.

Top module: `iq_pack_bridge`

## Requirements
- R1: In each 16-bit half of a write, bits 6..0 hold the I sample with bit 6 inverted and bits 5..0 unchanged, and bit 7 is 0. Signed value v therefore appears as v+64.
- R2: In each 16-bit half, bits 14..8 hold the Q sample with its top bit inverted, and bit 15 is 0.
- R3: Bits 15..0 of a write hold the first sample of the pair, and bits 31..16 hold the second. The byte order from low to high is therefore I0, Q0, I1, Q1.
- R4: `wr_en` is high for exactly one cycle. That cycle is the one after the clock edge that took the second valid sample of a pair. At no other time is it high.
- R5: While `smp_valid` is low, the I and Q inputs have no effect on any later write.
- R6: `pkt_end` is high only together with `wr_en`, and only on the write that carries sample number `PKT_SAMPLES` of the packet.
- R7: After a packet ends, the next packet ends exactly `PKT_SAMPLES` valid samples later.
- R8: A synchronous active-high `rst` clears `wr_en`, `wr_word` and `pkt_end`. It discards a held odd sample and restarts the packet count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | High when `smp_i`/`smp_q` carry a sample |
| smp_i | input | 7 | Signed I sample |
| smp_q | input | 7 | Signed Q sample |
| wr_en | output | 1 | One-cycle write strobe toward the buffer |
| wr_word | output | 32 | Two packed samples, first in the low half |
| pkt_end | output | 1 | Marks the write carrying the last sample of a packet |

## Verification
The bench builds the block with `SAMPLE_W` = 7 and `PKT_SAMPLES` = 6. Every one of the 16384 I/Q combinations therefore passes through the formatter, and a packet boundary falls on every third write. This brings thousands of packet restarts within reach in a short run. Stretches with valid held every cycle are mixed with gapped stretches that drive junk inputs. Resets are applied both while a sample is held and in the middle of a packet.

// File: rtl/iq_pack_pkg.sv
package iq_pack_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } pair_state_t;
endpackage

// File: rtl/iq_word_fmt.sv
module iq_word_fmt #(
    parameter int SAMPLE_W = 7,
    localparam int FIELD_W = SAMPLE_W + 1,
    localparam int WORD_W  = 2 * FIELD_W
) (
    input  logic [SAMPLE_W-1:0] i_s,
    input  logic [SAMPLE_W-1:0] q_s,
    output logic [WORD_W-1:0]   word
);
    // Field 0 carries I, field 1 carries Q; each has a zero pad on top
    for (genvar f = 0; f < 2; f++) begin : g_field
        logic [SAMPLE_W-1:0] src;
        assign src = (f == 0) ? i_s : q_s;
        assign word[f*FIELD_W +: FIELD_W] = {1'b0, ~src[SAMPLE_W-1], src[SAMPLE_W-2:0]};
    end
endmodule

// File: rtl/iq_pair_fsm.sv
module iq_pair_fsm
    import iq_pack_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int OUT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              pair_done,
    output logic              wr_q,
    output logic [OUT_W-1:0]  word_q
);
    pair_state_t       state, state_nx;
    logic [WORD_W-1:0] held_q;

    always_comb begin
        state_nx  = state;
        pair_done = 1'b0;
        unique case (state)
            ST_EMPTY: if (in_valid) state_nx = ST_HELD;
            ST_HELD:  if (in_valid) begin
                state_nx  = ST_EMPTY;
                pair_done = 1'b1;
            end
            default:  state_nx = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            word_q <= '0;
            wr_q   <= 1'b0;
        end else begin
            wr_q <= pair_done;
            if (in_valid && state == ST_EMPTY) held_q <= in_word;
            if (pair_done) word_q <= {in_word, held_q};
        end
    end

    a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
        wr_q |=> !wr_q);
    a_r4_wr_after_pair: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> ($past(in_valid) && $past(state) == ST_HELD));
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state));
endmodule

// File: rtl/iq_pkt_counter.sv
module iq_pkt_counter #(
    parameter int PKT_SAMPLES = 734,
    localparam int PAIRS = PKT_SAMPLES / 2,
    localparam int CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic pair_done,
    output logic pkt_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAIRS - 1);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pkt_q <= 1'b0;
        end else begin
            pkt_q <= pair_done && (cnt == LAST);
            if (pair_done) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    a_r7_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    a_r6_pkt_at_last: assert property (@(posedge clk) disable iff (rst)
        pkt_q |-> ($past(cnt) == LAST && cnt == '0));
endmodule

// File: rtl/iq_pack_bridge.sv
module iq_pack_bridge #(
    parameter int SAMPLE_W    = 7,
    parameter int PKT_SAMPLES = 734,
    localparam int WORD_W = 2 * (SAMPLE_W + 1),
    localparam int OUT_W  = 2 * WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic [SAMPLE_W-1:0] smp_q,
    output logic                wr_en,
    output logic [OUT_W-1:0]    wr_word,
    output logic                pkt_end
);
    logic [WORD_W-1:0] fmt_word;
    logic              pair_done;
    logic              rst_d;

    iq_word_fmt #(.SAMPLE_W(SAMPLE_W)) u_fmt (
        .i_s  (smp_i),
        .q_s  (smp_q),
        .word (fmt_word)
    );

    iq_pair_fsm #(.WORD_W(WORD_W)) u_pair (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (smp_valid),
        .in_word   (fmt_word),
        .pair_done (pair_done),
        .wr_q      (wr_en),
        .word_q    (wr_word)
    );

    iq_pkt_counter #(.PKT_SAMPLES(PKT_SAMPLES)) u_pkt (
        .clk       (clk),
        .rst       (rst),
        .pair_done (pair_done),
        .pkt_q     (pkt_end)
    );

    a_r6_pkt_with_wr: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> wr_en);
    a_r1_pads_zero: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!wr_word[OUT_W-1] && !wr_word[OUT_W-1-SAMPLE_W-1]
                   && !wr_word[WORD_W-1] && !wr_word[SAMPLE_W]));

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d && !rst) begin
            a_r8_cleared: assert (!wr_en && !pkt_end && wr_word == '0);
        end
    end
endmodule

// File: tb/iq_pack_bridge_tb.sv
module iq_pack_bridge_tb;
    localparam int SW  = 7;
    localparam int PKT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [6:0]  smp_i = '0;
    logic [6:0]  smp_q = '0;
    logic        wr_en;
    logic [31:0] wr_word;
    logic        pkt_end;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // model state
    bit          have_first = 0;
    logic [15:0] first_w = '0;
    int          samp = 0;
    int          pkts = 0;
    bit          exp_wr = 0;
    bit          exp_pkt = 0;
    logic [31:0] exp_word = '0;

    always #2 clk = ~clk;

    iq_pack_bridge #(.SAMPLE_W(SW), .PKT_SAMPLES(PKT)) u_dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i),
        .smp_q(smp_q), .wr_en(wr_en), .wr_word(wr_word), .pkt_end(pkt_end)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] fmtw(input logic [6:0] i, input logic [6:0] q);
        logic [7:0] oi = {1'b0, i} + 8'd64;
        logic [7:0] oq = {1'b0, q} + 8'd64;
        return {1'b0, oq[6:0], 1'b0, oi[6:0]};
    endfunction

    // check outputs of the previous edge, then drive the next inputs
    task automatic step(input bit v, input logic [6:0] i, input logic [6:0] q, input bit r);
        @(negedge clk);
        chk(exp_wr ? "R4 write strobe" : "R5 no write", {31'd0, wr_en}, {31'd0, exp_wr});
        chk(pkts > 0 ? "R7 packet restart" : "R6 packet end", {31'd0, pkt_end}, {31'd0, exp_pkt});
        if (exp_wr) begin
            chk("R1 I fields", {wr_word[23:16], wr_word[7:0]}, {exp_word[23:16], exp_word[7:0]});
            chk("R2 Q fields", {wr_word[31:24], wr_word[15:8]}, {exp_word[31:24], exp_word[15:8]});
            chk("R3 pair order", wr_word, exp_word);
        end
        if (exp_pkt) pkts++;
        rst = r; smp_valid = v; smp_i = i; smp_q = q;
        exp_wr = 0; exp_pkt = 0;
        if (r) begin
            have_first = 0; samp = 0; exp_word = '0;
        end else if (v) begin
            if (have_first) begin
                exp_wr = 1;
                exp_word = {fmtw(i, q), first_w};
                samp += 2;
                exp_pkt = (samp == PKT);
                if (exp_pkt) samp = 0;
                have_first = 0;
            end else begin
                first_w = fmtw(i, q);
                have_first = 1;
            end
        end
    endtask

    initial begin
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 7'h55, 7'h2A, 0);
        // R8 reset state
        chk("R8 reset wr_en", {31'd0, wr_en}, 32'd0);
        chk("R8 reset word", wr_word, 32'd0);
        chk("R8 reset pkt_end", {31'd0, pkt_end}, 32'd0);

        // continuous sweep of all I/Q combinations
        for (int n = 0; n < 16384; n++) step(1, n[6:0], n[13:7], 0);

        // gapped stretch with junk on idle cycles (R5)
        for (int n = 0; n < 3000; n++) begin
            if (n % 3 == 1) step(0, 7'(n * 37), 7'(n * 11), 0);
            else            step(1, 7'(n * 5 + 3), 7'(n * 9 + 1), 0);
        end

        // R8: held odd sample discarded by reset
        step(1, 7'h7F, 7'h40, 0);
        step(0, 0, 0, 1);
        for (int n = 0; n < 40; n++) step(1, 7'(n + 100), 7'(60 - n), 0);

        // R8: reset mid-packet restarts count
        for (int n = 0; n < 4; n++) step(1, 7'(n), 7'(n), 0);
        step(0, 0, 0, 1);
        for (int n = 0; n < 30; n++) step(n % 2 == 0, 7'(n * 3), 7'(n * 7), 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule